// File: doc/BRIEF.md
# Memory Address Remap and Channel Decoder

This block sits between the request path and the DRAM channels of a memory controller. Each cycle it may accept one 40-bit physical request address with a valid strobe. It folds four scattered 256 MB physical windows in the low 4 GB into a single contiguous memory space. Each window's destination block is programmable. Addresses in the large upper region pass through unchanged. The translated memory address is then matched against per-channel chip-select ranges to pick a channel and one chip select.

Folding the windows first lets one chip select cover memory that is physically split. One example is the window at physical zero, which holds the processor exception vectors, together with the window at 0x00_8000_0000. Channels can run interleaved or independent. In interleaved mode one programmable memory-address bit picks the channel, and channel 0's range table serves both channels. In independent mode the channel comes from whichever channel's ranges contain the address. Configuration is loaded through a simple register-write port. Results appear one cycle after the request.

Top module: `mem_route_unit`

## Requirements
- R1: A physical address with bits [39:32] zero and bits [31:28] equal to 0x0, 0x8, 0x9 or 0xC falls in window 0, 1, 2 or 3. Its memory address is zero above bit 29, takes bits [29:28] from that window's 2-bit target field, and copies bits [27:0] from the request. The target fields sit in the map register (config address 0x00): window 0 in bits [1:0], window 1 in [3:2], window 2 in [5:4] and window 3 in [7:6].
- R2: After reset the map register holds 0xE4. Windows 0..3 therefore land on memory blocks 0..3, at memory addresses 0x00_0000_0000, 0x00_1000_0000, 0x00_2000_0000 and 0x00_3000_0000.
- R3: A physical address from 0x01_0000_0000 to 0x7F_FFFF_FFFF is output as the identical memory address.
- R4: A low address outside the four windows, and any address at or above 0x80_0000_0000, asserts o_miss and drives no chip select.
- R5: Each channel has four chip selects, driven one-hot on o_cs (bit n is chip select n). Each chip select has a start and an end register holding a 12-bit block number compared with memory address bits [39:28]. A hit needs start <= block < end. The start register of channel c, chip select s sits at config address 0x20 + 2*(4c+s), and its end register sits at the next address. A translated address that hits no range asserts o_miss.
- R6: When several ranges match, the lowest-numbered chip select wins. In independent mode channel 0 also wins over channel 1.
- R7: In independent mode, the mode register's bit 0 is 0. o_chan is the channel whose range table contains the address.
- R8: In interleaved mode, the mode register (config address 0x01) has bit 0 set. o_chan equals the memory-address bit whose index is in mode bits [13:8]. The chip select comes from channel 0's table only, and that bit still appears in o_maddr. Reset puts the index at 12 with interleave off.
- R9: Outputs are registered with one cycle of latency. o_valid follows i_valid, and back-to-back requests each give their own result. While o_valid is low, o_cs is zero and o_miss is low.
- R10: A configuration write takes effect on the cycle after the write. A request presented in the same cycle as the write still uses the old setting.
- R11: After reset all range registers are zero, so every request misses until ranges are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Request strobe |
| i_addr | input | 40 | Physical request address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| o_valid | output | 1 | Result valid, one cycle after i_valid |
| o_maddr | output | 40 | Translated memory address |
| o_chan | output | 1 | Selected channel |
| o_cs | output | 4 | One-hot chip select of the selected channel |
| o_miss | output | 1 | No window mapping or no range hit |

## Verification
On every cycle, the assertions check these invariants:
- the chip-select vector is one-hot or empty;
- a miss never drives a chip select, and a served request always drives one;
- requests at or above 0x80_0000_0000 always miss;
- upper-region addresses come out unchanged;
- low-window offsets keep their low 28 bits;
- o_valid tracks i_valid one cycle later, with quiet outputs while idle.

Other behaviours depend on programmed state and only the bench's directed scenarios can show them:
- which block a window is steered to;
- that a write takes effect exactly one cycle later and not in the cycle it is made;
- the chip-select and channel priority among overlapping ranges;
- that interleaved mode picks the channel from the chosen bit while using channel 0's table alone.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
    localparam int PA_W    = 40;
    localparam int BLK_LSB = 28;
    localparam int BLK_W   = PA_W - BLK_LSB;
    localparam int NUM_WIN = 4;
    localparam int TGT_W   = $clog2(NUM_WIN);
    localparam int NUM_CH  = 2;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int NUM_CS  = 4;
    localparam int POS_W   = $clog2(PA_W);
    localparam int CFG_AW  = 6;
    localparam int CFG_DW  = 32;
    localparam int HI_ZERO = 8;

    localparam logic [CFG_AW-1:0] ADDR_MAP  = 6'h00;
    localparam logic [CFG_AW-1:0] ADDR_MODE = 6'h01;
    localparam int                RNG_BASE  = 32;
    localparam int                POS_RST   = 12;
    localparam int                POS_LSB   = 8;

    typedef logic [NUM_WIN-1:0][TGT_W-1:0] win_map_t;

    typedef struct packed {
        logic             ilv_en;
        logic [POS_W-1:0] ilv_pos;
        win_map_t         win_tgt;
    } mode_t;

    typedef struct packed {
        logic            hit;
        logic [PA_W-1:0] maddr;
    } xlat_t;

    function automatic logic [3:0] win_nib(input int idx);
        case (idx)
            0:       return 4'h0;
            1:       return 4'h8;
            2:       return 4'h9;
            default: return 4'hC;
        endcase
    endfunction

    function automatic win_map_t tgt_identity();
        win_map_t r;
        for (int i = 0; i < NUM_WIN; i++) r[i] = TGT_W'(i);
        return r;
    endfunction

    function automatic xlat_t translate(input logic [PA_W-1:0] pa, input win_map_t tgt);
        xlat_t r;
        r.hit   = 1'b0;
        r.maddr = pa;
        if (pa[PA_W-1 -: HI_ZERO] == '0) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (pa[BLK_LSB +: 4] == win_nib(i)) begin
                    r.hit   = 1'b1;
                    r.maddr = '0;
                    r.maddr[BLK_LSB-1:0]       = pa[BLK_LSB-1:0];
                    r.maddr[BLK_LSB +: TGT_W]  = tgt[i];
                end
            end
        end else if (!pa[PA_W-1]) begin
            r.hit = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/mrd_cfg_regs.sv
module mrd_cfg_regs
    import mrd_pkg::*;
(
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cfg_we,
    input  logic [CFG_AW-1:0]                     cfg_addr,
    input  logic [CFG_DW-1:0]                     cfg_wdata,
    output mode_t                                 mode,
    output logic [NUM_CH-1:0][NUM_CS-1:0][BLK_W-1:0] rng_lo,
    output logic [NUM_CH-1:0][NUM_CS-1:0][BLK_W-1:0] rng_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode.ilv_en  <= 1'b0;
            mode.ilv_pos <= POS_W'(POS_RST);
            mode.win_tgt <= tgt_identity();
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_MAP) begin
                mode.win_tgt <= cfg_wdata[NUM_WIN*TGT_W-1:0];
            end else if (cfg_addr == ADDR_MODE) begin
                mode.ilv_en  <= cfg_wdata[0];
                mode.ilv_pos <= cfg_wdata[POS_LSB +: POS_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rng_lo <= '0;
            rng_hi <= '0;
        end else if (cfg_we) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int s = 0; s < NUM_CS; s++) begin
                    if (cfg_addr == CFG_AW'(RNG_BASE + 2*(c*NUM_CS+s)))
                        rng_lo[c][s] <= cfg_wdata[BLK_W-1:0];
                    if (cfg_addr == CFG_AW'(RNG_BASE + 2*(c*NUM_CS+s) + 1))
                        rng_hi[c][s] <= cfg_wdata[BLK_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/mrd_window_xlat.sv
module mrd_window_xlat
    import mrd_pkg::*;
(
    input  logic [PA_W-1:0] pa,
    input  win_map_t        tgt,
    output logic            hit,
    output logic [PA_W-1:0] maddr
);
    xlat_t res;
    always_comb res = translate(pa, tgt);
    assign hit   = res.hit;
    assign maddr = res.maddr;
endmodule

// File: rtl/mrd_cs_match.sv
module mrd_cs_match
    import mrd_pkg::*;
#(
    parameter int N = NUM_CS
) (
    input  logic [BLK_W-1:0]        blk,
    input  logic [N-1:0][BLK_W-1:0] lo,
    input  logic [N-1:0][BLK_W-1:0] hi,
    output logic                    any,
    output logic [N-1:0]            pick
);
    logic [N-1:0] hit;

    for (genvar s = 0; s < N; s++) begin : g_cmp
        assign hit[s] = (lo[s] <= blk) && (blk < hi[s]);
    end

    always_comb begin
        pick = '0;
        for (int s = N-1; s >= 0; s--) begin
            if (hit[s]) begin
                pick    = '0;
                pick[s] = 1'b1;
            end
        end
    end

    assign any = |hit;
endmodule

// File: rtl/mem_route_unit.sv
module mem_route_unit
    import mrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              i_valid,
    input  logic [PA_W-1:0]   i_addr,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic              o_valid,
    output logic [PA_W-1:0]   o_maddr,
    output logic [CH_W-1:0]   o_chan,
    output logic [NUM_CS-1:0] o_cs,
    output logic              o_miss
);
    mode_t                                    mode;
    logic [NUM_CH-1:0][NUM_CS-1:0][BLK_W-1:0] rng_lo;
    logic [NUM_CH-1:0][NUM_CS-1:0][BLK_W-1:0] rng_hi;
    logic                                     xl_hit;
    logic [PA_W-1:0]                          xl_maddr;
    logic [NUM_CH-1:0]                        ch_any;
    logic [NUM_CH-1:0][NUM_CS-1:0]            ch_pick;
    logic                                     nxt_hit;
    logic [CH_W-1:0]                          nxt_chan;
    logic [NUM_CS-1:0]                        nxt_cs;

    mrd_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mode(mode), .rng_lo(rng_lo), .rng_hi(rng_hi)
    );

    mrd_window_xlat u_xlat (
        .pa(i_addr), .tgt(mode.win_tgt), .hit(xl_hit), .maddr(xl_maddr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mrd_cs_match #(.N(NUM_CS)) u_match (
            .blk (xl_maddr[PA_W-1:BLK_LSB]),
            .lo  (rng_lo[c]),
            .hi  (rng_hi[c]),
            .any (ch_any[c]),
            .pick(ch_pick[c])
        );
    end

    always_comb begin
        nxt_hit  = 1'b0;
        nxt_chan = '0;
        nxt_cs   = '0;
        if (xl_hit) begin
            if (mode.ilv_en) begin
                nxt_hit = ch_any[0];
                nxt_cs  = ch_pick[0];
                if (ch_any[0] && (int'(mode.ilv_pos) < PA_W))
                    nxt_chan = CH_W'(xl_maddr[mode.ilv_pos]);
            end else begin
                for (int c = NUM_CH-1; c >= 0; c--) begin
                    if (ch_any[c]) begin
                        nxt_hit  = 1'b1;
                        nxt_cs   = ch_pick[c];
                        nxt_chan = CH_W'(c);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_valid <= 1'b0;
            o_maddr <= '0;
            o_chan  <= '0;
            o_cs    <= '0;
            o_miss  <= 1'b0;
        end else begin
            o_valid <= i_valid;
            o_maddr <= xl_maddr;
            o_chan  <= i_valid ? nxt_chan : '0;
            o_cs    <= i_valid ? nxt_cs : '0;
            o_miss  <= i_valid && !nxt_hit;
        end
    end
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker
    import mrd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              i_valid,
    input logic [PA_W-1:0]   i_addr,
    input logic              o_valid,
    input logic [PA_W-1:0]   o_maddr,
    input logic [CH_W-1:0]   o_chan,
    input logic [NUM_CS-1:0] o_cs,
    input logic              o_miss
);
    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(o_cs));

    p_miss_no_cs_r4: assert property (@(posedge clk) disable iff (rst)
        o_miss |-> (o_cs == '0));

    p_served_has_cs_r5: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_miss) |-> ($countones(o_cs) == 1));

    p_high_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_addr[PA_W-1]) |=> (o_miss && o_cs == '0));

    p_upper_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (i_valid && !i_addr[PA_W-1] && (i_addr[PA_W-2:32] != '0))
        |=> (o_maddr == $past(i_addr)));

    p_low_offset_r1: assert property (@(posedge clk) disable iff (rst)
        (i_valid && i_addr[PA_W-1:32] == '0 && !o_miss)
        |=> (o_maddr[BLK_LSB-1:0] == $past(i_addr[BLK_LSB-1:0])));

    p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);

    p_valid_fall_r9: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !o_valid |-> (o_cs == '0 && !o_miss && o_chan == '0));
endmodule

bind mem_route_unit mrd_checker u_chk (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_addr(i_addr),
    .o_valid(o_valid), .o_maddr(o_maddr), .o_chan(o_chan),
    .o_cs(o_cs), .o_miss(o_miss)
);

// File: tb/mem_route_unit_tb.sv
module mem_route_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_valid = 1'b0;
    logic [39:0] i_addr = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        o_valid;
    logic [39:0] o_maddr;
    logic [0:0]  o_chan;
    logic [3:0]  o_cs;
    logic        o_miss;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mem_route_unit u_dut (
        .clk(clk), .rst(rst), .i_valid(i_valid), .i_addr(i_addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .o_valid(o_valid), .o_maddr(o_maddr), .o_chan(o_chan),
        .o_cs(o_cs), .o_miss(o_miss)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_range(input int ch, input int cs, input int lo, input int hi);
        cfg_write(6'(32 + 2*(ch*4+cs)), 32'(lo));
        cfg_write(6'(32 + 2*(ch*4+cs) + 1), 32'(hi));
    endtask

    task automatic expect_out(input string tag, input logic [39:0] ma, input logic ch,
                              input logic [3:0] cs, input logic miss);
        chk({tag, " valid"}, 64'(o_valid), 64'(1));
        chk({tag, " maddr"}, 64'(o_maddr), 64'(ma));
        chk({tag, " chan"},  64'(o_chan),  64'(ch));
        chk({tag, " cs"},    64'(o_cs),    64'(cs));
        chk({tag, " miss"},  64'(o_miss),  64'(miss));
    endtask

    task automatic send(input string tag, input logic [39:0] pa, input logic [39:0] ma,
                        input logic ch, input logic [3:0] cs, input logic miss);
        @(negedge clk);
        i_valid = 1'b1; i_addr = pa;
        @(negedge clk);
        i_valid = 1'b0;
        expect_out(tag, ma, ch, cs, miss);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", 64'(o_valid), 64'(0));
        chk("R9 reset cs", 64'(o_cs), 64'(0));
        chk("R9 reset miss", 64'(o_miss), 64'(0));
        rst = 1'b0;
        send("R11 no ranges", 40'h00_0000_1234, 40'h00_0000_1234, 1'b0, 4'b0, 1'b1);
    endtask

    task automatic t_default_map();
        send("R2 win1", 40'h00_8000_0010, 40'h00_1000_0010, 1'b0, 4'b0, 1'b1);
        send("R2 win2", 40'h00_9ABC_DEF0, 40'h00_2ABC_DEF0, 1'b0, 4'b0, 1'b1);
        send("R2 win3", 40'h00_C000_0004, 40'h00_3000_0004, 1'b0, 4'b0, 1'b1);
    endtask

    task automatic t_remap();
        // write and request in the same cycle: old map still applies (R10)
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'h00; cfg_wdata = 32'h1B;
        i_valid = 1'b1; i_addr = 40'h00_8000_0000;
        @(negedge clk);
        cfg_we = 1'b0;
        expect_out("R10 same cycle old", 40'h00_1000_0000, 1'b0, 4'b0, 1'b1);
        @(negedge clk);
        i_valid = 1'b0;
        expect_out("R10 next cycle new", 40'h00_2000_0000, 1'b0, 4'b0, 1'b1);
        send("R1 win1 to blk2", 40'h00_8123_4567, 40'h00_2123_4567, 1'b0, 4'b0, 1'b1);
        send("R1 win0 to blk3", 40'h00_0000_0040, 40'h00_3000_0040, 1'b0, 4'b0, 1'b1);
        send("R1 win3 to blk0", 40'h00_CFFF_FFFF, 40'h00_0FFF_FFFF, 1'b0, 4'b0, 1'b1);
        cfg_write(6'h00, 32'hE4);
    endtask

    task automatic t_unmapped();
        send("R4 low gap", 40'h00_4000_0000, 40'h00_4000_0000, 1'b0, 4'b0, 1'b1);
        send("R4 at 0x80", 40'h80_0000_0000, 40'h80_0000_0000, 1'b0, 4'b0, 1'b1);
        send("R4 top", 40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 1'b0, 4'b0, 1'b1);
    endtask

    task automatic t_upper();
        send("R3 upper low end", 40'h01_0000_0000, 40'h01_0000_0000, 1'b0, 4'b0, 1'b1);
        send("R3 upper high end", 40'h7F_FFFF_FFFF, 40'h7F_FFFF_FFFF, 1'b0, 4'b0, 1'b1);
    endtask

    task automatic t_ranges();
        set_range(0, 0, 'h000, 'h002);
        set_range(0, 1, 'h002, 'h004);
        set_range(1, 0, 'h010, 'h020);
        send("R5 blk0 cs0", 40'h00_0000_0000, 40'h00_0000_0000, 1'b0, 4'b0001, 1'b0);
        send("R5 span windows", 40'h00_8000_0000, 40'h00_1000_0000, 1'b0, 4'b0001, 1'b0);
        send("R5 blk2 cs1", 40'h00_9000_0000, 40'h00_2000_0000, 1'b0, 4'b0010, 1'b0);
        send("R5 blk3 cs1", 40'h00_C000_0000, 40'h00_3000_0000, 1'b0, 4'b0010, 1'b0);
        send("R7 ch1 hit", 40'h01_0000_0000, 40'h01_0000_0000, 1'b1, 4'b0001, 1'b0);
        send("R5 end exclusive", 40'h02_0000_0000, 40'h02_0000_0000, 1'b0, 4'b0000, 1'b1);
    endtask

    task automatic t_priority();
        set_range(0, 2, 'h000, 'h004);
        set_range(1, 1, 'h000, 'h001);
        set_range(0, 3, 'h010, 'h011);
        send("R6 low cs wins", 40'h00_0000_0000, 40'h00_0000_0000, 1'b0, 4'b0001, 1'b0);
        send("R6 ch0 over ch1", 40'h01_0000_0000, 40'h01_0000_0000, 1'b0, 4'b1000, 1'b0);
        send("R7 ch1 only", 40'h01_1000_0000, 40'h01_1000_0000, 1'b1, 4'b0001, 1'b0);
    endtask

    task automatic t_interleave();
        cfg_write(6'h01, 32'h0000_0C01);
        send("R8 bit12 set", 40'h00_0000_1000, 40'h00_0000_1000, 1'b1, 4'b0001, 1'b0);
        send("R8 bit12 clear", 40'h00_0000_0000, 40'h00_0000_0000, 1'b0, 4'b0001, 1'b0);
        send("R8 ch0 table", 40'h01_0000_1000, 40'h01_0000_1000, 1'b1, 4'b1000, 1'b0);
        send("R8 ch1 table unused", 40'h01_1000_0000, 40'h01_1000_0000, 1'b0, 4'b0000, 1'b1);
        send("R8 blk2", 40'h00_9000_0000, 40'h00_2000_0000, 1'b0, 4'b0010, 1'b0);
        cfg_write(6'h01, 32'h0000_1C01);
        send("R8 bit28 select", 40'h00_8000_0000, 40'h00_1000_0000, 1'b1, 4'b0001, 1'b0);
        cfg_write(6'h01, 32'h0000_0C00);
    endtask

    task automatic t_pipeline();
        @(negedge clk);
        i_valid = 1'b1; i_addr = 40'h00_0000_0000;
        @(negedge clk);
        expect_out("R9 b2b first", 40'h00_0000_0000, 1'b0, 4'b0001, 1'b0);
        i_addr = 40'h01_1000_0000;
        @(negedge clk);
        expect_out("R9 b2b second", 40'h01_1000_0000, 1'b1, 4'b0001, 1'b0);
        i_addr = 40'h00_4000_0000;
        @(negedge clk);
        expect_out("R9 b2b third", 40'h00_4000_0000, 1'b0, 4'b0000, 1'b1);
        i_valid = 1'b0;
        @(negedge clk);
        chk("R9 idle valid", 64'(o_valid), 64'(0));
        chk("R9 idle cs", 64'(o_cs), 64'(0));
        chk("R9 idle miss", 64'(o_miss), 64'(0));
    endtask

    initial begin
        t_reset();
        t_default_map();
        t_remap();
        t_unmapped();
        t_upper();
        t_ranges();
        t_priority();
        t_interleave();
        t_pipeline();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule